// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a digital step attenuator and turns a 5-bit attenuation request into a transfer on the three-wire serial control interface. The interface has a serial clock, a serial data line and a latch strobe. A one-cycle start strobe launches a transfer. The block then shifts out a 6-bit word, most significant bit first. The first five bits are the request, from the 16 dB weight down to the 1 dB weight, and the sixth is a stop bit that is always zero. After the last bit the block raises the latch strobe and drops it again, which makes the target apply the new setting.

Every timing minimum of the interface is given as a parameter in picoseconds. These are clock high time, clock low time, the minimum serial clock period, data setup before a rising edge, data hold after a falling edge, latch setup after the last falling edge, and latch pulse width. Each one is converted to a whole number of system clock cycles, rounded up, using a system-clock-period parameter. The serial pins are driven from flops. The block reports `busy` for the whole transfer and a one-cycle `done` when the latch strobe has returned low.

Top module: `atten_ser_master`

## Requirements
- R1: After reset the serial clock, serial data, latch strobe, busy and done outputs are all low.
- R2: On the rising serial clock edges, a transfer presents atten_i[4] first and atten_i[0] fifth, followed by a sixth bit that is always 0. There are exactly six rising edges before the latch strobe rises.
- R3: The latch strobe is low throughout the shifting. It is never high while the serial clock is high.
- R4: Each serial clock high phase lasts at least HI cycles. Each low phase between two rising edges lasts at least LO cycles. HI and LO are each the larger of the ceiling of the high (or low) minimum and the ceiling of half the minimum serial clock period, counted in system clocks.
- R5: Serial data never changes while the serial clock is high. It has been stable for at least the setup minimum (in cycles) at each rising edge. After each falling edge it stays unchanged for at least the hold minimum (in cycles).
- R6: The latch strobe rises no sooner than the latch setup minimum (in cycles) after the last falling serial clock edge. It then stays high for at least the latch pulse-width minimum (in cycles).
- R7: busy_o is high from the cycle after an accepted start until done. done_o is a single-cycle pulse in the cycle the latch strobe returns low, with busy_o already low in that cycle.
- R8: A start strobe that arrives while busy_o is high is ignored. The word in flight is unchanged and no second transfer follows.
- R9: While busy_o is low, the serial clock and serial data outputs are low.
- R10: A start strobe in the same cycle that done_o pulses is accepted and begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to program a new setting |
| atten_i | input | 5 | Requested attenuation, bit 4 = 16 dB weight, bit 0 = 1 dB weight |
| ser_clk_o | output | 1 | Serial clock to the attenuator |
| ser_data_o | output | 1 | Serial data to the attenuator |
| ser_le_o | output | 1 | Latch strobe to the attenuator |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the latch strobe has returned low |

## Verification
Two events can collide here. One is the end of a transfer, when done pulses and the latch strobe falls. The other is the acceptance of a new start. The bench provokes this by raising start in exactly the cycle done is seen. It then judges that the next word appears on the pins with full setup time and that done has already pulsed once. The bench also presents start during the shifting and during the latch pulse. In those cases it judges that the word sampled at the rising edges is still the earlier request, and that no further clock edges follow the completed transfer.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

    localparam int ATT_W  = 5;
    localparam int WORD_W = ATT_W + 1;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD,
        PH_LATCH
    } phase_e;

    function automatic int cyc_ceil(input int ps, input int per_ps);
        return (ps + per_ps - 1) / per_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R4: a loaded count never jumps upward unless reloaded
    AST_TMR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) && $past(rst_n) |-> cnt_q <= $past(cnt_q)) // R4
        else $error("timer count rose without load");

endmodule

// File: rtl/atten_word_frame.sv
module atten_word_frame
    import atten_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [ATT_W-1:0]  att_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) begin
            word_d = {att_i, 1'b0};
        end else if (shift_i) begin
            word_d = {word_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

    AST_STOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> word_q[0] == 1'b0) // R2
        else $error("stop bit not zero after load");

endmodule

// File: rtl/atten_ser_master.sv
module atten_ser_master
    import atten_ser_pkg::*;
#(
    parameter int SYS_CLK_PS        = 10000,
    parameter int T_SCLK_PERIOD_PS  = 100000,
    parameter int T_SCLK_HIGH_PS    = 30000,
    parameter int T_SCLK_LOW_PS     = 30000,
    parameter int T_DATA_SETUP_PS   = 10000,
    parameter int T_DATA_HOLD_PS    = 10000,
    parameter int T_LATCH_SETUP_PS  = 10000,
    parameter int T_LATCH_WIDTH_PS  = 30000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ATT_W-1:0] atten_i,
    output logic             ser_clk_o,
    output logic             ser_data_o,
    output logic             ser_le_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int HALF_PS  = (T_SCLK_PERIOD_PS + 1) / 2;
    localparam int HI_CYC   = imax(imax(cyc_ceil(T_SCLK_HIGH_PS, SYS_CLK_PS),
                                        cyc_ceil(HALF_PS, SYS_CLK_PS)), 1);
    localparam int LO_CYC   = imax(imax(cyc_ceil(T_SCLK_LOW_PS, SYS_CLK_PS),
                                        cyc_ceil(HALF_PS, SYS_CLK_PS)), 1);
    localparam int SU_CYC   = imax(cyc_ceil(T_DATA_SETUP_PS, SYS_CLK_PS), 1);
    localparam int HD_CYC   = imax(cyc_ceil(T_DATA_HOLD_PS, SYS_CLK_PS), 1);
    localparam int GAP_CYC  = imax(LO_CYC - HD_CYC, SU_CYC);
    localparam int TAIL_CYC = imax(cyc_ceil(T_LATCH_SETUP_PS, SYS_CLK_PS), HD_CYC);
    localparam int PW_CYC   = imax(cyc_ceil(T_LATCH_WIDTH_PS, SYS_CLK_PS), 1);
    localparam int MAX_CYC  = imax(imax(imax(HI_CYC, GAP_CYC), imax(HD_CYC, TAIL_CYC)), PW_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] bit_idx;
        logic             sclk;
        logic             sdat;
        logic             le;
        logic             busy;
        logic             done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ph: PH_IDLE, bit_idx: '0, sclk: 1'b0, sdat: 1'b0,
                                 le: 1'b0, busy: 1'b0, done: 1'b0};

    ctl_t ctl_d, ctl_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              frm_load;
    logic              frm_shift;
    logic [WORD_W-1:0] frm_word;
    logic              last_bit;

    atten_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    atten_word_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frm_load),
        .shift_i (frm_shift),
        .att_i   (atten_i),
        .word_o  (frm_word)
    );

    assign last_bit = (ctl_q.bit_idx == IDX_W'(WORD_W - 1));

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        frm_load  = 1'b0;
        frm_shift = 1'b0;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    ctl_d.ph      = PH_SETUP;
                    ctl_d.busy    = 1'b1;
                    ctl_d.bit_idx = '0;
                    ctl_d.sdat    = atten_i[ATT_W-1];
                    frm_load      = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = CNT_W'(GAP_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (tmr_zero) begin
                    ctl_d.ph   = PH_HIGH;
                    ctl_d.sclk = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(HI_CYC - 1);
                end
            end
            PH_HIGH: begin
                if (tmr_zero) begin
                    ctl_d.ph   = PH_HOLD;
                    ctl_d.sclk = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = last_bit ? CNT_W'(TAIL_CYC - 1) : CNT_W'(HD_CYC - 1);
                end
            end
            PH_HOLD: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (last_bit) begin
                        ctl_d.ph = PH_LATCH;
                        ctl_d.le = 1'b1;
                        tmr_val  = CNT_W'(PW_CYC - 1);
                    end else begin
                        ctl_d.ph      = PH_SETUP;
                        ctl_d.bit_idx = ctl_q.bit_idx + IDX_W'(1);
                        ctl_d.sdat    = frm_word[WORD_W-2];
                        frm_shift     = 1'b1;
                        tmr_val       = CNT_W'(GAP_CYC - 1);
                    end
                end
            end
            PH_LATCH: begin
                if (tmr_zero) begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.le   = 1'b0;
                    ctl_d.sdat = 1'b0;
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                end
            end
            default: begin
                ctl_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ser_clk_o  = ctl_q.sclk;
    assign ser_data_o = ctl_q.sdat;
    assign ser_le_o   = ctl_q.le;
    assign busy_o     = ctl_q.busy;
    assign done_o     = ctl_q.done;

    AST_LE_SCLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.le && ctl_q.sclk)) // R3
        else $error("latch strobe high with serial clock high");

    AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.sclk) |-> $stable(ctl_q.sdat)) // R5
        else $error("data moved at rising edge");

    AST_DATA_STABLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.sclk) |-> $stable(ctl_q.sdat)) // R5
        else $error("data moved at falling edge");

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |=> !ctl_q.done) // R7
        else $error("done wider than one cycle");

    AST_DONE_AT_LE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> $fell(ctl_q.le) && !ctl_q.busy) // R7
        else $error("done not aligned with latch strobe fall");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.busy |-> !ctl_q.sclk && !ctl_q.sdat) // R9
        else $error("serial lines active while idle");

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.busy) |-> $past(start_i)) // R8
        else $error("busy rose without start");

endmodule

// File: tb/tb_atten_ser_master.sv
`timescale 1ns/1ps
module tb_atten_ser_master;

    localparam int TCK_NS = 10;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int B_HI   = mx(ceil_div(30, TCK_NS), ceil_div(50, TCK_NS));
    localparam int B_LO   = mx(ceil_div(30, TCK_NS), ceil_div(50, TCK_NS));
    localparam int B_SU   = ceil_div(10, TCK_NS);
    localparam int B_HD   = ceil_div(10, TCK_NS);
    localparam int B_LESU = ceil_div(10, TCK_NS);
    localparam int B_PW   = ceil_div(30, TCK_NS);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] atten = '0;
    logic       sclk, sdat, le, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    int n_cyc = 0;
    logic [4:0] exp_req = '0;

    always #(TCK_NS/2) clk = ~clk;

    atten_ser_master dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .atten_i    (atten),
        .ser_clk_o  (sclk),
        .ser_data_o (sdat),
        .ser_le_o   (le),
        .busy_o     (busy),
        .done_o     (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] frame_of(input logic [4:0] v);
        return {v, 1'b0};
    endfunction

    // pin monitor, sampled on the falling system clock edge
    logic p_sclk = 0, p_sdat = 0, p_le = 0, p_busy = 0, p_done = 0;
    int since_rise = 0, since_fall = 1000, since_dchg = 1000, since_le = 0;
    int rises = 0, rises_after_done = 0, n_done = 0;
    logic [5:0] cap = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            since_rise++; since_fall++; since_dchg++; since_le++;
            if (busy && !p_busy) begin
                rises = 0;
                cap = '0;
            end
            if (sdat != p_sdat) begin
                chk(!sclk, "R5 data change while clock high", int'(sclk), 0);
                if (busy && rises > 0)
                    chk(since_fall >= B_HD, "R5 hold after fall", since_fall, B_HD);
                since_dchg = 0;
            end
            if (sclk && !p_sclk) begin
                chk(since_dchg >= B_SU, "R5 setup before rise", since_dchg, B_SU);
                if (rises > 0)
                    chk(since_fall >= B_LO, "R4 low width", since_fall, B_LO);
                cap = {cap[4:0], sdat};
                rises++;
                rises_after_done++;
                since_rise = 0;
            end
            if (!sclk && p_sclk) begin
                chk(since_rise >= B_HI, "R4 high width", since_rise, B_HI);
                since_fall = 0;
            end
            if (le && !p_le) begin
                chk(rises == 6, "R2 rising edge count", rises, 6);
                chk(cap == frame_of(exp_req), "R2 word order", int'(cap), int'(frame_of(exp_req)));
                chk(since_fall >= B_LESU, "R6 latch setup", since_fall, B_LESU);
                since_le = 0;
            end
            if (!le && p_le) begin
                chk(since_le >= B_PW, "R6 latch width", since_le, B_PW);
                chk(done == 1'b1, "R7 done with latch fall", int'(done), 1);
            end
            if (done) begin
                chk(!busy && p_busy, "R7 busy low at done", int'(busy), 0);
                chk(!p_done, "R7 done one cycle", int'(p_done), 0);
                n_done++;
                rises_after_done = 0;
            end
            if (le && sclk) chk(1'b0, "R3 latch with clock high", 1, 0);
            if (!busy && (sclk || sdat))
                chk(1'b0, "R9 lines idle", int'({sclk, sdat}), 0);
            p_sclk = sclk; p_sdat = sdat; p_le = le; p_busy = busy; p_done = done;
        end
    end

    // drive a start one cycle long; called just after a falling edge
    task automatic launch(input logic [4:0] v, input bit accept);
        #1;
        start = 1'b1;
        atten = v;
        if (accept) exp_req = v;
        @(negedge clk);
        #1;
        start = 1'b0;
        if (accept) chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic xfer(input logic [4:0] v);
        @(negedge clk);
        launch(v, 1'b1);
        wait_done();
    endtask

    initial begin : watchdog
        while (n_cyc < 150000) begin
            @(posedge clk);
            n_cyc++;
        end
        chk(1'b0, "watchdog expired", n_cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        int base_done;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk({sclk, sdat, le, busy, done} == 5'b0, "R1 reset state",
            int'({sclk, sdat, le, busy, done}), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({sclk, sdat, le, busy, done} == 5'b0, "R1 state after reset release",
            int'({sclk, sdat, le, busy, done}), 0);

        // directed corners
        xfer(5'd0);
        xfer(5'd31);
        xfer(5'h15);
        xfer(5'h0A);
        xfer(5'h10);
        xfer(5'h01);

        // random settings
        for (int i = 0; i < 20; i++) begin
            xfer(5'($urandom_range(0, 31)));
        end

        // R8: start during shifting is ignored
        @(negedge clk);
        launch(5'h13, 1'b1);
        repeat (15) @(negedge clk);
        launch(5'h0C, 1'b0);
        wait_done();
        // R8: start during latch pulse is ignored
        @(negedge clk);
        launch(5'h1E, 1'b1);
        do @(negedge clk); while (!le);
        launch(5'h01, 1'b0);
        base_done = n_done;
        wait_done();
        repeat (30) @(negedge clk);
        chk(rises_after_done == 0, "R8 no extra transfer", rises_after_done, 0);
        chk(busy == 1'b0, "R8 idle after ignored start", int'(busy), 0);
        chk(n_done == base_done + 1, "R8 single done", n_done, base_done + 1);

        // R10: start in the cycle done pulses
        @(negedge clk);
        launch(5'h07, 1'b1);
        for (int k = 0; k < 4; k++) begin
            wait_done();
            launch(5'($urandom_range(0, 31)), 1'b1);
            chk(busy == 1'b1, "R10 start at done accepted", int'(busy), 1);
        end
        wait_done();
        repeat (10) @(negedge clk);
        chk(!sclk && !sdat && !le, "R9 idle after run", int'({sclk, sdat, le}), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule